// File: doc/BRIEF.md
# Dual-Mode Floating-Point Register Bank

This block is the architectural register storage for a floating-point coprocessor. It holds 32 registers of 64 bits each and serves two read ports and two write ports every cycle. Each port carries a register number, a precision flag (single or double) and a data bus. A mode input, driven from a bit of the processor status register, selects how the registers are viewed.

In wide mode every register is a full 64-bit double-precision register. In paired mode each register holds one single-precision value in its low 32 bits. A double-precision operand is then formed from an even register and the odd register above it, so only 16 double registers are visible. A double access that names an odd register in paired mode is illegal. It is flagged and leaves the storage untouched. Both write ports may hit the same storage in one cycle, and port 0 wins. Read data is registered, so a read returns the contents as they stood before any write issued in the same cycle.

Top module: `fpr_bank`

## Requirements
- R1: Synchronous active-high reset clears all 32 registers to zero and clears both read data outputs and all four illegal-operand flags.
- R2: In wide mode (`mode64`=1), a double write (`dbl`=1) to register n stores all 64 bits in register n, and a double read of n returns them. Any register number, odd or even, is legal.
- R3: A single write (`dbl`=0) stores data bits [31:0] into the low half of register n and leaves its high half unchanged, in either mode. A single read returns the low half of n zero-extended to 64 bits.
- R4: In paired mode (`mode64`=0), a double access to even register n maps bits [31:0] to the low half of register n and bits [63:32] to the low half of register n+1, for both reads and writes.
- R5: In paired mode, a double write to an odd register changes no stored bit. It raises that write port's illegal flag (`wrX_bad`) one cycle after the request.
- R6: In paired mode, a double read of an odd register returns all-zero data and raises that read port's illegal flag (`rdX_bad`), with the same latency as the data.
- R7: When both write ports write the same 32-bit half of the same register in one cycle, port 0's data is stored. Halves written by only one port take that port's data.
- R8: Read data and read flags appear one clock after the address is presented. A read in the same cycle as a write to that register returns the old contents, and a read in the next cycle returns the new contents.
- R9: Changing `mode64` leaves the stored contents unchanged. A value written in one mode is read back in the other mode according to R2 to R4.
- R10: The two read ports are independent and may read any two registers, including the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 = wide mode, 0 = paired mode |
| rd0_addr | input | 5 | Read port 0 register number |
| rd0_dbl | input | 1 | Read port 0 precision, 1 = double |
| rd0_data | output | 64 | Read port 0 data, registered |
| rd0_bad | output | 1 | Read port 0 illegal-operand flag |
| rd1_addr | input | 5 | Read port 1 register number |
| rd1_dbl | input | 1 | Read port 1 precision, 1 = double |
| rd1_data | output | 64 | Read port 1 data, registered |
| rd1_bad | output | 1 | Read port 1 illegal-operand flag |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | 5 | Write port 0 register number |
| wr0_dbl | input | 1 | Write port 0 precision, 1 = double |
| wr0_data | input | 64 | Write port 0 data |
| wr0_bad | output | 1 | Write port 0 illegal-operand flag, registered |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 5 | Write port 1 register number |
| wr1_dbl | input | 1 | Write port 1 precision, 1 = double |
| wr1_data | input | 64 | Write port 1 data |
| wr1_bad | output | 1 | Write port 1 illegal-operand flag, registered |

## Verification
The bench builds the bank with its default parameters: 32 registers of 64 bits. At this size the top pair (registers 30 and 31) and the odd register 31 can be reached, so the edge of the pair mapping and the illegal odd case are both exercised at the highest index. A reference model of the two halves of every register predicts each read and flag. The stimulus covers mode switches with live contents, same-cycle read-after-write, and write collisions on one half, on different halves, and across a register pair.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;

  // A double access in paired mode must name an even register.
  function automatic logic pair_illegal(input logic mode64, input logic dbl, input logic lsb);
    return !mode64 && dbl && lsb;
  endfunction

endpackage

// File: rtl/fpr_wr_decode.sv
`timescale 1ns/1ps
module fpr_wr_decode
  import fpr_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 64,
  localparam int HW  = DW / 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     mode64,
  input  logic                     en,
  input  logic [AW-1:0]            addr,
  input  logic                     dbl,
  input  logic [DW-1:0]            data,
  output logic [NREG-1:0]          lo_we,
  output logic [NREG-1:0]          hi_we,
  output logic [NREG-1:0][HW-1:0]  lo_d,
  output logic [NREG-1:0][HW-1:0]  hi_d,
  output logic                     bad
);

  logic          ok;
  logic          pair;
  logic [AW-1:0] odd_mate;

  assign bad      = en && pair_illegal(mode64, dbl, addr[0]);
  assign ok       = en && !bad;
  assign pair     = dbl && !mode64;
  assign odd_mate = {addr[AW-1:1], 1'b1};

  for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
    logic hit_n;
    logic hit_m;
    assign hit_n     = (addr == AW'(gi));
    assign hit_m     = pair && (odd_mate == AW'(gi)) && !hit_n;
    assign lo_we[gi] = ok && (hit_n || hit_m);
    assign lo_d[gi]  = hit_m ? data[DW-1:HW] : data[HW-1:0];
    assign hi_we[gi] = ok && dbl && mode64 && hit_n;
    assign hi_d[gi]  = data[DW-1:HW];
  end

  always_comb begin
    if (bad) begin
      assert_odd_pair_inert_R5: assert (lo_we == '0 && hi_we == '0);
    end
    if (en && !dbl) begin
      assert_single_low_only_R3: assert (hi_we == '0 && $countones(lo_we) == 1);
    end
    if (!mode64) begin
      assert_pair_no_high_R4: assert (hi_we == '0);
    end
  end

endmodule

// File: rtl/fpr_store.sv
`timescale 1ns/1ps
module fpr_store #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREG-1:0]         we0,
  input  logic [NREG-1:0][W-1:0]  d0,
  input  logic [NREG-1:0]         we1,
  input  logic [NREG-1:0][W-1:0]  d1,
  output logic [NREG-1:0][W-1:0]  arr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      arr <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we0[i])      arr[i] <= d0[i];
        else if (we1[i]) arr[i] <= d1[i];
      end
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_chk
    assert_port0_wins_R7: assert property (@(posedge clk) disable iff (rst)
      we0[gi] |=> arr[gi] == $past(d0[gi]));
    assert_port1_alone_R7: assert property (@(posedge clk) disable iff (rst)
      (we1[gi] && !we0[gi]) |=> arr[gi] == $past(d1[gi]));
  end

endmodule

// File: rtl/fpr_rd_port.sv
`timescale 1ns/1ps
module fpr_rd_port
  import fpr_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 64,
  localparam int HW  = DW / 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode64,
  input  logic [AW-1:0]            addr,
  input  logic                     dbl,
  input  logic [NREG-1:0][HW-1:0]  lo_arr,
  input  logic [NREG-1:0][HW-1:0]  hi_arr,
  output logic [DW-1:0]            data_q,
  output logic                     bad_q
);

  logic [DW-1:0] nxt;
  logic          ill;

  always_comb begin
    ill = pair_illegal(mode64, dbl, addr[0]);
    if (ill)         nxt = '0;
    else if (!dbl)   nxt = {{HW{1'b0}}, lo_arr[addr]};
    else if (mode64) nxt = {hi_arr[addr], lo_arr[addr]};
    else             nxt = {lo_arr[{addr[AW-1:1], 1'b1}], lo_arr[addr]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      data_q <= nxt;
      bad_q  <= ill;
    end
  end

  assert_bad_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    bad_q |-> data_q == '0);

endmodule

// File: rtl/fpr_bank.sv
`timescale 1ns/1ps
module fpr_bank #(
  parameter int NREG = 32,
  parameter int DW   = 64,
  localparam int HW  = DW / 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode64,
  input  logic [AW-1:0]  rd0_addr,
  input  logic           rd0_dbl,
  output logic [DW-1:0]  rd0_data,
  output logic           rd0_bad,
  input  logic [AW-1:0]  rd1_addr,
  input  logic           rd1_dbl,
  output logic [DW-1:0]  rd1_data,
  output logic           rd1_bad,
  input  logic           wr0_en,
  input  logic [AW-1:0]  wr0_addr,
  input  logic           wr0_dbl,
  input  logic [DW-1:0]  wr0_data,
  output logic           wr0_bad,
  input  logic           wr1_en,
  input  logic [AW-1:0]  wr1_addr,
  input  logic           wr1_dbl,
  input  logic [DW-1:0]  wr1_data,
  output logic           wr1_bad
);

  logic [NREG-1:0]          lo_we0, hi_we0, lo_we1, hi_we1;
  logic [NREG-1:0][HW-1:0]  lo_d0, hi_d0, lo_d1, hi_d1;
  logic [NREG-1:0][HW-1:0]  lo_arr, hi_arr;
  logic                     bad0_c, bad1_c;

  fpr_wr_decode #(.NREG(NREG), .DW(DW)) u_dec0 (
    .mode64(mode64), .en(wr0_en), .addr(wr0_addr), .dbl(wr0_dbl), .data(wr0_data),
    .lo_we(lo_we0), .hi_we(hi_we0), .lo_d(lo_d0), .hi_d(hi_d0), .bad(bad0_c));

  fpr_wr_decode #(.NREG(NREG), .DW(DW)) u_dec1 (
    .mode64(mode64), .en(wr1_en), .addr(wr1_addr), .dbl(wr1_dbl), .data(wr1_data),
    .lo_we(lo_we1), .hi_we(hi_we1), .lo_d(lo_d1), .hi_d(hi_d1), .bad(bad1_c));

  fpr_store #(.NREG(NREG), .W(HW)) u_lo (
    .clk(clk), .rst(rst), .we0(lo_we0), .d0(lo_d0), .we1(lo_we1), .d1(lo_d1), .arr(lo_arr));

  fpr_store #(.NREG(NREG), .W(HW)) u_hi (
    .clk(clk), .rst(rst), .we0(hi_we0), .d0(hi_d0), .we1(hi_we1), .d1(hi_d1), .arr(hi_arr));

  fpr_rd_port #(.NREG(NREG), .DW(DW)) u_rd0 (
    .clk(clk), .rst(rst), .mode64(mode64), .addr(rd0_addr), .dbl(rd0_dbl),
    .lo_arr(lo_arr), .hi_arr(hi_arr), .data_q(rd0_data), .bad_q(rd0_bad));

  fpr_rd_port #(.NREG(NREG), .DW(DW)) u_rd1 (
    .clk(clk), .rst(rst), .mode64(mode64), .addr(rd1_addr), .dbl(rd1_dbl),
    .lo_arr(lo_arr), .hi_arr(hi_arr), .data_q(rd1_data), .bad_q(rd1_bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr0_bad <= 1'b0;
      wr1_bad <= 1'b0;
    end else begin
      wr0_bad <= bad0_c;
      wr1_bad <= bad1_c;
    end
  end

  assert_wr0_flag_cause_R5: assert property (@(posedge clk) disable iff (rst)
    wr0_bad |-> $past(wr0_en && !mode64 && wr0_dbl && wr0_addr[0]));
  assert_wr1_flag_cause_R5: assert property (@(posedge clk) disable iff (rst)
    wr1_bad |-> $past(wr1_en && !mode64 && wr1_dbl && wr1_addr[0]));
  assert_rd_flag_mode_R6: assert property (@(posedge clk) disable iff (rst)
    rd0_bad |-> $past(!mode64 && rd0_dbl && rd0_addr[0]));

endmodule

// File: tb/tb_fpr_bank.sv
`timescale 1ns/1ps
module tb_fpr_bank;

  localparam int NREG = 32;
  localparam int DW   = 64;
  localparam int HW   = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          mode64 = 1'b1;
  logic [AW-1:0] r0a = '0, r1a = '0, w0a = '0, w1a = '0;
  logic          r0d = 1'b0, r1d = 1'b0, w0d = 1'b0, w1d = 1'b0;
  logic          w0e = 1'b0, w1e = 1'b0;
  logic [DW-1:0] w0x = '0, w1x = '0;
  logic [DW-1:0] rd0_data, rd1_data;
  logic          rd0_bad, rd1_bad, wr0_bad, wr1_bad;

  fpr_bank #(.NREG(NREG), .DW(DW)) dut (
    .clk(clk), .rst(rst), .mode64(mode64),
    .rd0_addr(r0a), .rd0_dbl(r0d), .rd0_data(rd0_data), .rd0_bad(rd0_bad),
    .rd1_addr(r1a), .rd1_dbl(r1d), .rd1_data(rd1_data), .rd1_bad(rd1_bad),
    .wr0_en(w0e), .wr0_addr(w0a), .wr0_dbl(w0d), .wr0_data(w0x), .wr0_bad(wr0_bad),
    .wr1_en(w1e), .wr1_addr(w1a), .wr1_dbl(w1d), .wr1_data(w1x), .wr1_bad(wr1_bad));

  typedef struct {
    bit            c0, c1, cw;
    logic [DW-1:0] e0, e1;
    bit            b0, b1, wb0, wb1;
    string         tag;
  } item_t;

  item_t         q[$];
  int            vectors = 0;
  int            fails = 0;
  logic [HW-1:0] mlo [NREG];
  logic [HW-1:0] mhi [NREG];

  task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void mrd(input logic [AW-1:0] a, input bit dbl,
                              output logic [DW-1:0] d, output bit b);
    b = 1'b0;
    if (dbl && !mode64 && a[0]) begin b = 1'b1; d = '0; end
    else if (!dbl)  d = {32'h0, mlo[a]};
    else if (mode64) d = {mhi[a], mlo[a]};
    else d = {mlo[a | 5'd1], mlo[a]};
  endfunction

  function automatic bit mwr(input bit en, input logic [AW-1:0] a, input bit dbl,
                             input logic [DW-1:0] x);
    if (!en) return 1'b0;
    if (dbl && !mode64 && a[0]) return 1'b1;
    mlo[a] = x[HW-1:0];
    if (dbl && mode64) mhi[a] = x[DW-1:HW];
    if (dbl && !mode64) mlo[a | 5'd1] = x[DW-1:HW];
    return 1'b0;
  endfunction

  // Driver: inputs are already set; predict, push, advance one cycle.
  task automatic step(string tag, bit c0, bit c1, bit cw);
    item_t it;
    it.tag = tag; it.c0 = c0; it.c1 = c1; it.cw = cw;
    mrd(r0a, r0d, it.e0, it.b0);
    mrd(r1a, r1d, it.e1, it.b1);
    it.wb1 = mwr(w1e, w1a, w1d, w1x);
    it.wb0 = mwr(w0e, w0a, w0d, w0x);
    q.push_back(it);
    @(negedge clk);
    w0e = 1'b0; w1e = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a0, input bit d0, input logic [AW-1:0] a1, input bit d1);
    r0a = a0; r0d = d0; r1a = a1; r1d = d1;
  endtask

  task automatic wr0(input logic [AW-1:0] a, input bit d, input logic [DW-1:0] x);
    w0e = 1'b1; w0a = a; w0d = d; w0x = x;
  endtask

  task automatic wr1(input logic [AW-1:0] a, input bit d, input logic [DW-1:0] x);
    w1e = 1'b1; w1a = a; w1d = d; w1x = x;
  endtask

  // Monitor: outputs settle just after the edge that follows the request.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.c0) begin
        cmp(it.tag, "rd0_data", rd0_data, it.e0);
        cmp(it.tag, "rd0_bad", {63'h0, rd0_bad}, {63'h0, it.b0});
      end
      if (it.c1) begin
        cmp(it.tag, "rd1_data", rd1_data, it.e1);
        cmp(it.tag, "rd1_bad", {63'h0, rd1_bad}, {63'h0, it.b1});
      end
      if (it.cw) begin
        cmp(it.tag, "wr0_bad", {63'h0, wr0_bad}, {63'h0, it.wb0});
        cmp(it.tag, "wr1_bad", {63'h0, wr1_bad}, {63'h0, it.wb1});
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin mlo[i] = '0; mhi[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset
    cmp("R1", "rd0_data", rd0_data, '0);
    cmp("R1", "rd1_data", rd1_data, '0);
    cmp("R1", "flags", {60'h0, rd0_bad, rd1_bad, wr0_bad, wr1_bad}, '0);

    // R1, R10: every register reads zero, two ports on different registers
    for (int i = 0; i < NREG; i++) begin
      rd(AW'(i), 1'b1, AW'(NREG - 1 - i), 1'b1);
      step("R1", 1, 1, 1);
    end

    // R2: wide mode, both ports fill registers with full doubles
    mode64 = 1'b1;
    for (int i = 0; i < NREG; i += 2) begin
      wr0(AW'(i), 1'b1, {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)});
      wr1(AW'(i + 1), 1'b1, {32'hB100_0000 + 32'(i), 32'h6100_0000 + 32'(i)});
      step("R2", 0, 0, 1);
    end
    for (int i = 0; i < NREG; i++) begin
      rd(AW'(i), 1'b1, AW'(i), 1'b1);   // R10: same register on both ports
      step("R2", 1, 1, 0);
    end

    // R8: read in the write cycle sees old, next cycle sees new
    rd(5'd7, 1'b1, 5'd7, 1'b1);
    wr0(5'd7, 1'b1, 64'h0123_4567_89AB_CDEF);
    step("R8", 1, 1, 1);
    step("R8", 1, 1, 0);

    // R3: single write keeps the high half; single read zero-extends
    wr1(5'd9, 1'b0, 64'hFFFF_FFFF_CAFE_F00D);
    step("R3", 0, 0, 1);
    rd(5'd9, 1'b1, 5'd9, 1'b0);
    step("R3", 1, 1, 0);

    // R9: switch to paired mode, contents kept
    mode64 = 1'b0;
    rd(5'd9, 1'b0, 5'd30, 1'b0);
    step("R9", 1, 1, 0);

    // R4: paired double reads and writes, including the top pair
    rd(5'd4, 1'b1, 5'd30, 1'b1);
    step("R4", 1, 1, 0);
    wr0(5'd30, 1'b1, 64'hDEAD_BEEF_1234_5678);
    wr1(5'd12, 1'b1, 64'h1111_2222_3333_4444);
    step("R4", 0, 0, 1);
    rd(5'd30, 1'b0, 5'd31, 1'b0);
    step("R4", 1, 1, 0);
    rd(5'd12, 1'b1, 5'd13, 1'b0);
    step("R4", 1, 1, 0);

    // R5: odd double write in paired mode is flagged and inert
    wr0(5'd31, 1'b1, 64'h9999_9999_9999_9999);
    wr1(5'd13, 1'b1, 64'h7777_7777_7777_7777);
    step("R5", 0, 0, 1);
    rd(5'd30, 1'b1, 5'd12, 1'b1);
    step("R5", 1, 1, 1);
    rd(5'd31, 1'b0, 5'd13, 1'b0);
    step("R5", 1, 1, 0);

    // R6: odd double read in paired mode
    rd(5'd31, 1'b1, 5'd3, 1'b1);
    step("R6", 1, 1, 0);

    // R7: collision on same half; pair mate collides with a single
    wr0(5'd20, 1'b0, 64'h0000_0000_AAAA_0000);
    wr1(5'd20, 1'b0, 64'h0000_0000_BBBB_0000);
    step("R7", 0, 0, 1);
    wr0(5'd4, 1'b1, 64'hC0C0_C0C0_0D0D_0D0D);
    wr1(5'd5, 1'b0, 64'h0000_0000_E1E1_E1E1);
    step("R7", 0, 0, 1);
    rd(5'd20, 1'b0, 5'd4, 1'b1);
    step("R7", 1, 1, 0);

    // R7 in wide mode: port 0 low half only, port 1 whole register
    mode64 = 1'b1;
    wr0(5'd6, 1'b0, 64'h0000_0000_1357_9BDF);
    wr1(5'd6, 1'b1, 64'h2468_ACE0_FFFF_EEEE);
    step("R7", 0, 0, 1);
    rd(5'd6, 1'b1, 5'd6, 1'b0);
    step("R7", 1, 1, 0);

    // R9, R2: back to wide mode, paired writes read as whole registers; odd legal
    rd(5'd30, 1'b1, 5'd31, 1'b1);
    step("R9", 1, 1, 0);
    wr0(5'd11, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0);
    step("R2", 0, 0, 1);
    rd(5'd11, 1'b1, 5'd11, 1'b1);
    step("R2", 1, 1, 1);

    rd(5'd0, 1'b0, 5'd0, 1'b0);
    step("idle", 0, 0, 0);
    repeat (3) @(negedge clk);
    report();
    $finish;
  end

endmodule